// File: doc/BRIEF.md
# Speculative Transaction Cache Controller

This block is a private first-level data cache for one processor. It lets that processor run hardware transactions. Each of its direct-mapped lines holds one data word, an invalid/shared/modified coherence state and one extra flag that marks the line as speculative. Plain reads and writes behave like an ordinary write-back, write-allocate cache.

Inside a transaction, stores mark their line speculative. The transaction then ends in one of two ways. A commit clears every speculative flag in a single cycle, so the new data becomes ordinary modified data. An abort drops every speculative line to invalid, so the next access fetches the value that was in memory before the transaction. Because a begin first cleans every dirty line out to memory, that value is always current.

The cache talks to other processors through a broadcast request port. A request asks either for a shared copy or for ownership of a line. Each reply carries a flag that says whether some other processor holds that line under a speculative write. If that flag is raised during a transaction, the local transaction gives up. The same happens when a miss would have to evict a speculative line. The processor sees a single-cycle abort pulse that arrives together with the response to the request that failed. The next memory level sits behind a simple request/acknowledge port.

Top module: `spec_tx_cache`

## Requirements
- R1: After reset no transaction is active, every line is invalid, `req_ready` is high and `resp_valid`, `tx_abort`, `bus_req`, `mem_rd` and `mem_wr` are low. The first read of any address therefore misses.
- R2: A read miss issues one bus request with `bus_own`=0, then one memory read, and returns the memory word. A later read hit returns the cached word with no bus or memory traffic. Line index is address bits [3:0] and tag is the bits above them.
- R3: A begin (`req_op`=2) outside a transaction writes every modified line back to memory before it responds. `tx_active` is high from its response onward. A begin inside a transaction responds with no memory traffic and no change.
- R4: A write (`req_op`=1) to a line that is not modified issues one bus request with `bus_own`=1. A write to a line that is already modified issues no bus request. A write miss allocates the line without a memory read.
- R5: Inside a transaction, a bus reply with `bus_conflict` high aborts the local transaction. This holds for both reads and writes. `tx_abort` pulses for one cycle together with `resp_valid`, `tx_active` falls, and every speculative line becomes invalid.
- R6: A commit (`req_op`=3) keeps all speculatively written data as ordinary modified lines and ends the transaction. A later begin writes that data to memory.
- R7: An explicit abort (`req_op`=4) invalidates exactly the speculative lines, ends the transaction without a `tx_abort` pulse, and leaves non-speculative lines intact.
- R8: Inside a transaction, a miss whose victim line is speculative aborts the transaction as in R5, without touching memory.
- R9: No memory write occurs while a transaction is active, so speculative data never reaches memory.
- R10: Commit or abort outside a transaction responds and changes nothing.
- R11: Outside a transaction, `bus_conflict` is ignored and the access completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe, taken when `req_ready` is high |
| req_op | input | 3 | 0 read, 1 write, 2 begin, 3 commit, 4 abort |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Controller idle and able to take a request |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W | Read result, valid with `resp_valid` on reads |
| tx_active | output | 1 | A transaction is open |
| tx_abort | output | 1 | One-cycle pulse: transaction forcibly aborted |
| bus_req | output | 1 | Broadcast request, held until `bus_ack` |
| bus_own | output | 1 | 1 ownership request, 0 shared read |
| bus_addr | output | ADDR_W | Broadcast address |
| bus_ack | input | 1 | Broadcast completed |
| bus_conflict | input | 1 | Another processor holds the line speculatively written, valid with `bus_ack` |
| mem_rd | output | 1 | Next-level read, held until `mem_ack` |
| mem_wr | output | 1 | Next-level write, held until `mem_ack` |
| mem_addr | output | ADDR_W | Next-level address |
| mem_wdata | output | DATA_W | Next-level write data |
| mem_rdata | input | DATA_W | Next-level read data, valid with `mem_ack` |
| mem_ack | input | 1 | Next-level completion |

## Verification
The bench compares memory contents before and after a begin that follows both a plain store and a commit. A begin that skipped the flush, or a commit that invalidated lines instead of clearing their flags, would leave stale words in memory.

After every forced or explicit abort, the bench reads the aborted address again. It expects the pre-transaction memory word and exactly one new memory read. An abort that left speculative lines valid would return the speculative data. An abort that invalidated too much would cause an extra fetch on an untouched line.

The bench also raises `bus_conflict` outside a transaction, and it evicts a speculative line. A controller that aborted without an open transaction would show up in the first case. One that wrote speculative data back to memory would show up in the second.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHD = 2'd1,
    LS_MOD = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_BEGIN  = 3'd2,
    OP_COMMIT = 3'd3,
    OP_ABORT  = 3'd4
  } cpu_op_e;

endpackage

// File: rtl/stx_data_ram.sv
module stx_data_ram #(
  parameter int LINES  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [LINES];

  // Simple dual-port storage with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    rdata <= mem_q[raddr];
  end

endmodule

// File: rtl/stx_line_table.sv
module stx_line_table
  import stx_pkg::*;
#(
  parameter int LINES = 16,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output line_st_e         rd_st,
  output logic             rd_spec,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st,
  input  logic             wr_spec,
  input  logic             gang_commit,
  input  logic             gang_abort,
  output logic [LINES-1:0] dirty_vec
);

  logic [LINES-1:0][1:0]       st_all;
  logic [LINES-1:0]            spec_all;
  logic [LINES-1:0][TAG_W-1:0] tag_all;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e         st_r;
    logic             spec_r;
    logic [TAG_W-1:0] tag_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_r   <= LS_INV;
        spec_r <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        st_r   <= wr_st;
        spec_r <= wr_spec;
      end else if (gang_abort && spec_r) begin
        st_r   <= LS_INV;
        spec_r <= 1'b0;
      end else if (gang_commit) begin
        spec_r <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) tag_r <= wr_tag;
    end

    assign st_all[g]    = st_r;
    assign spec_all[g]  = spec_r;
    assign tag_all[g]   = tag_r;
    assign dirty_vec[g] = (st_r == LS_MOD);
  end

  assign rd_st   = line_st_e'(st_all[rd_idx]);
  assign rd_spec = spec_all[rd_idx];
  assign rd_tag  = tag_all[rd_idx];

endmodule

// File: rtl/spec_tx_cache.sv
module spec_tx_cache
  import stx_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              tx_active,
  output logic              tx_abort,
  output logic              bus_req,
  output logic              bus_own,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_ack,
  input  logic              bus_conflict,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_EVICT, S_BUS, S_FILL, S_SCAN, S_FLWB, S_FLWAIT
  } fsm_e;

  fsm_e              state;
  cpu_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  fl_idx;

  logic [IDX_W-1:0]  addr_idx;
  logic [TAG_W-1:0]  addr_tag;
  assign addr_idx = addr_q[IDX_W-1:0];
  assign addr_tag = addr_q[ADDR_W-1:IDX_W];

  // Line table and data storage
  logic [IDX_W-1:0]  lt_ri, lt_wi, ram_ra;
  logic [TAG_W-1:0]  rd_tag, lt_tag;
  line_st_e          rd_st, lt_st;
  logic              rd_spec, lt_spec, lt_we;
  logic              gang_c, gang_a;
  logic [LINES-1:0]  dirty_vec;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wd, ram_q;

  stx_line_table #(.LINES(LINES), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst(rst),
    .rd_idx(lt_ri), .rd_tag(rd_tag), .rd_st(rd_st), .rd_spec(rd_spec),
    .wr_en(lt_we), .wr_idx(lt_wi), .wr_tag(lt_tag), .wr_st(lt_st),
    .wr_spec(lt_spec), .gang_commit(gang_c), .gang_abort(gang_a),
    .dirty_vec(dirty_vec)
  );

  stx_data_ram #(.LINES(LINES), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(lt_wi), .wdata(ram_wd),
    .raddr(ram_ra), .rdata(ram_q)
  );

  // Lowest-numbered dirty line, used by the begin-time flush
  logic [IDX_W-1:0] fd_idx;
  always_comb begin
    fd_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (dirty_vec[i]) fd_idx = IDX_W'(i);
    end
  end

  logic flushing;
  assign flushing = (state == S_FLWB) || (state == S_FLWAIT);
  assign lt_ri    = flushing ? fl_idx : addr_idx;

  always_comb begin
    case (state)
      S_IDLE:  ram_ra = req_addr[IDX_W-1:0];
      S_SCAN:  ram_ra = fd_idx;
      default: ram_ra = addr_idx;
    endcase
  end

  logic hit, is_acc, victim_spec, look_abort, bus_abort;
  assign hit         = (rd_st != LS_INV) && (rd_tag == addr_tag);
  assign is_acc      = (op_q == OP_READ) || (op_q == OP_WRITE);
  assign victim_spec = (rd_st != LS_INV) && rd_spec;
  assign look_abort  = is_acc && !hit && victim_spec && tx_active;
  assign bus_abort   = bus_ack && bus_conflict && tx_active;

  // Table and RAM write controls
  always_comb begin
    lt_we   = 1'b0;
    lt_wi   = addr_idx;
    lt_tag  = addr_tag;
    lt_st   = LS_INV;
    lt_spec = 1'b0;
    ram_we  = 1'b0;
    ram_wd  = wdata_q;
    gang_c  = 1'b0;
    gang_a  = 1'b0;
    case (state)
      S_LOOK: begin
        if (op_q == OP_COMMIT) gang_c = tx_active;
        if (op_q == OP_ABORT)  gang_a = tx_active;
        if (look_abort)        gang_a = 1'b1;
        if (op_q == OP_WRITE && hit && rd_st == LS_MOD) begin
          lt_we   = 1'b1;
          lt_st   = LS_MOD;
          lt_spec = rd_spec | tx_active;
          ram_we  = 1'b1;
        end
      end
      S_BUS: begin
        if (bus_abort) begin
          gang_a = 1'b1;
        end else if (bus_ack && op_q == OP_WRITE) begin
          lt_we   = 1'b1;
          lt_st   = LS_MOD;
          lt_spec = tx_active;
          ram_we  = 1'b1;
        end
      end
      S_FILL: begin
        if (mem_ack) begin
          lt_we  = 1'b1;
          lt_st  = LS_SHD;
          ram_we = 1'b1;
          ram_wd = mem_rdata;
        end
      end
      S_FLWAIT: begin
        if (mem_ack) begin
          lt_we  = 1'b1;
          lt_wi  = fl_idx;
          lt_tag = rd_tag;
          lt_st  = LS_SHD;
        end
      end
      default: ;
    endcase
  end

  assign req_ready = (state == S_IDLE);

  // Sequencer and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      wdata_q    <= '0;
      fl_idx     <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      tx_active  <= 1'b0;
      tx_abort   <= 1'b0;
      bus_req    <= 1'b0;
      bus_own    <= 1'b0;
      bus_addr   <= '0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      resp_valid <= 1'b0;
      tx_abort   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= cpu_op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            state   <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (op_q == OP_BEGIN) begin
            if (tx_active) begin
              resp_valid <= 1'b1;
              state      <= S_IDLE;
            end else begin
              state <= S_SCAN;
            end
          end else if (!is_acc) begin
            tx_active  <= 1'b0;
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end else if (hit && (op_q == OP_READ || rd_st == LS_MOD)) begin
            resp_rdata <= ram_q;
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end else if (look_abort) begin
            tx_active  <= 1'b0;
            tx_abort   <= 1'b1;
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end else if (!hit && rd_st == LS_MOD) begin
            mem_wr    <= 1'b1;
            mem_addr  <= {rd_tag, addr_idx};
            mem_wdata <= ram_q;
            state     <= S_EVICT;
          end else begin
            bus_req  <= 1'b1;
            bus_own  <= (op_q == OP_WRITE);
            bus_addr <= addr_q;
            state    <= S_BUS;
          end
        end
        S_EVICT: begin
          if (mem_ack) begin
            mem_wr   <= 1'b0;
            bus_req  <= 1'b1;
            bus_own  <= (op_q == OP_WRITE);
            bus_addr <= addr_q;
            state    <= S_BUS;
          end
        end
        S_BUS: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            if (bus_abort) begin
              tx_active  <= 1'b0;
              tx_abort   <= 1'b1;
              resp_valid <= 1'b1;
              state      <= S_IDLE;
            end else if (op_q == OP_READ) begin
              mem_rd   <= 1'b1;
              mem_addr <= addr_q;
              state    <= S_FILL;
            end else begin
              resp_valid <= 1'b1;
              state      <= S_IDLE;
            end
          end
        end
        S_FILL: begin
          if (mem_ack) begin
            mem_rd     <= 1'b0;
            resp_rdata <= mem_rdata;
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end
        end
        S_SCAN: begin
          if (dirty_vec == '0) begin
            tx_active  <= 1'b1;
            resp_valid <= 1'b1;
            state      <= S_IDLE;
          end else begin
            fl_idx <= fd_idx;
            state  <= S_FLWB;
          end
        end
        S_FLWB: begin
          mem_wr    <= 1'b1;
          mem_addr  <= {rd_tag, fl_idx};
          mem_wdata <= ram_q;
          state     <= S_FLWAIT;
        end
        S_FLWAIT: begin
          if (mem_ack) begin
            mem_wr <= 1'b0;
            state  <= S_SCAN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic resp_valid,
  input logic tx_active,
  input logic tx_abort,
  input logic bus_req,
  input logic bus_ack,
  input logic mem_rd,
  input logic mem_wr
);

  a_r5_abort_with_resp: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> resp_valid);

  a_r5_abort_closes_tx: assert property (@(posedge clk) disable iff (rst)
    tx_abort |-> (!tx_active && $past(tx_active)));

  a_r9_no_spec_writeback: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> !tx_active);

  a_r2_bus_held: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> bus_req);

  a_r2_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r3_resp_single: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  a_r3_resp_when_idle: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);

endmodule

bind spec_tx_cache stx_checker u_chk (.*);

// File: tb/sim_spec_tx_cache.sv
module sim_spec_tx_cache;
  timeunit 1ns; timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [7:0] req_addr = 8'd0, req_wdata = 8'd0;
  logic       req_ready, resp_valid, tx_active, tx_abort;
  logic [7:0] resp_rdata;
  logic       bus_req, bus_own, bus_ack, bus_conflict;
  logic [7:0] bus_addr;
  logic       mem_rd, mem_wr, mem_ack;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  spec_tx_cache u0 (.*);

  // Behavioural next level and broadcast bus
  logic [7:0] mem_model [256];
  bit         other_spec [256];
  int n_shr = 0, n_own = 0, n_mrd = 0, n_mwr = 0;
  int n_chk = 0, n_err = 0, cyc = 0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_model[i]  = 8'(i) ^ 8'h5A;
      other_spec[i] = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_conflict <= 1'b0; mem_ack <= 1'b0; mem_rdata <= '0;
    end else begin
      bus_ack <= bus_req && !bus_ack;
      bus_conflict <= other_spec[bus_addr];
      if (bus_req && !bus_ack) begin
        if (bus_own) n_own <= n_own + 1; else n_shr <= n_shr + 1;
      end
      mem_ack <= (mem_rd || mem_wr) && !mem_ack;
      if (mem_wr && !mem_ack) begin
        mem_model[mem_addr] <= mem_wdata;
        n_mwr <= n_mwr + 1;
      end
      if (mem_rd && !mem_ack) begin
        mem_rdata <= mem_model[mem_addr];
        n_mrd <= n_mrd + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_err = n_err + 1;
      $display("FAIL R1 watchdog act=%0d exp=<50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] rd_v;
  logic       ab_v;

  task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    rd_v = resp_rdata;
    ab_v = tx_abort;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tx_active", int'(tx_active), 0);
    check("R1 idle outputs", int'({resp_valid, tx_abort, bus_req, mem_rd, mem_wr}), 0);
    check("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_read_miss_hit();
    int s = n_shr, m = n_mrd;
    do_op(3'd0, 8'h13, 8'h00);
    check("R1 R2 miss data", int'(rd_v), 8'h49);
    check("R2 miss shared req", n_shr - s, 1);
    check("R2 miss mem read", n_mrd - m, 1);
    do_op(3'd0, 8'h13, 8'h00);
    check("R2 hit data", int'(rd_v), 8'h49);
    check("R2 hit no traffic", (n_shr - s) + (n_mrd - m), 2);
  endtask

  task automatic t_plain_writes();
    int o = n_own, m = n_mrd;
    do_op(3'd1, 8'h13, 8'hA1);
    check("R4 shared write owns", n_own - o, 1);
    other_spec[8'h24] = 1'b1;
    do_op(3'd1, 8'h24, 8'hB2);
    other_spec[8'h24] = 1'b0;
    check("R11 no abort outside tx", int'(ab_v), 0);
    check("R4 miss write owns", n_own - o, 2);
    check("R4 miss write no fill", n_mrd - m, 0);
    do_op(3'd0, 8'h24, 8'h00);
    check("R11 write kept", int'(rd_v), 8'hB2);
  endtask

  task automatic t_begin_flush();
    int w = n_mwr;
    do_op(3'd2, 8'h00, 8'h00);
    check("R3 flush count", n_mwr - w, 2);
    check("R3 flushed 13", int'(mem_model[8'h13]), 8'hA1);
    check("R3 flushed 24", int'(mem_model[8'h24]), 8'hB2);
    check("R3 tx open", int'(tx_active), 1);
    w = n_mwr;
    do_op(3'd2, 8'h00, 8'h00);
    check("R3 nested begin quiet", n_mwr - w, 0);
    check("R3 nested begin keeps tx", int'(tx_active), 1);
  endtask

  task automatic t_tx_write_commit();
    int o = n_own, w;
    do_op(3'd1, 8'h13, 8'hC3);
    check("R4 tx write owns", n_own - o, 1);
    do_op(3'd1, 8'h13, 8'hC4);
    check("R4 modified write silent", n_own - o, 1);
    do_op(3'd0, 8'h13, 8'h00);
    check("R4 tx read back", int'(rd_v), 8'hC4);
    check("R9 memory untouched", int'(mem_model[8'h13]), 8'hA1);
    do_op(3'd3, 8'h00, 8'h00);
    check("R6 commit closes", int'(tx_active), 0);
    check("R6 commit no pulse", int'(ab_v), 0);
    do_op(3'd0, 8'h13, 8'h00);
    check("R6 committed data", int'(rd_v), 8'hC4);
    w = n_mwr;
    do_op(3'd2, 8'h00, 8'h00);
    check("R6 committed line written", n_mwr - w, 1);
    check("R6 memory has commit", int'(mem_model[8'h13]), 8'hC4);
  endtask

  task automatic t_explicit_abort();
    int m;
    do_op(3'd1, 8'h24, 8'hD5);
    do_op(3'd4, 8'h00, 8'h00);
    check("R7 abort closes", int'(tx_active), 0);
    check("R7 no forced pulse", int'(ab_v), 0);
    m = n_mrd;
    do_op(3'd0, 8'h24, 8'h00);
    check("R7 old value", int'(rd_v), 8'hB2);
    check("R7 refetch", n_mrd - m, 1);
    m = n_mrd;
    do_op(3'd0, 8'h13, 8'h00);
    check("R7 clean line kept", int'(rd_v), 8'hC4);
    check("R7 clean line hit", n_mrd - m, 0);
  endtask

  task automatic t_conflict_write();
    int m;
    do_op(3'd2, 8'h00, 8'h00);
    do_op(3'd1, 8'h35, 8'h11);
    other_spec[8'h46] = 1'b1;
    do_op(3'd1, 8'h46, 8'h77);
    other_spec[8'h46] = 1'b0;
    check("R5 write conflict pulse", int'(ab_v), 1);
    check("R5 write conflict closes", int'(tx_active), 0);
    @(negedge clk);
    check("R5 pulse one cycle", int'(tx_abort), 0);
    m = n_mrd;
    do_op(3'd0, 8'h35, 8'h00);
    check("R5 spec line dropped", int'(rd_v), 8'h6F);
    check("R5 refetch", n_mrd - m, 1);
    check("R9 spec never stored", int'(mem_model[8'h35]), 8'h6F);
  endtask

  task automatic t_conflict_read();
    do_op(3'd2, 8'h00, 8'h00);
    do_op(3'd1, 8'h07, 8'h22);
    other_spec[8'h58] = 1'b1;
    do_op(3'd0, 8'h58, 8'h00);
    other_spec[8'h58] = 1'b0;
    check("R5 read conflict pulse", int'(ab_v), 1);
    check("R5 read conflict closes", int'(tx_active), 0);
    do_op(3'd0, 8'h07, 8'h00);
    check("R5 read abort drops spec", int'(rd_v), 8'h5D);
  endtask

  task automatic t_evict_abort();
    int w;
    do_op(3'd2, 8'h00, 8'h00);
    do_op(3'd1, 8'h09, 8'h33);
    w = n_mwr;
    do_op(3'd0, 8'h19, 8'h00);
    check("R8 evict aborts", int'(ab_v), 1);
    check("R8 tx closed", int'(tx_active), 0);
    check("R8 R9 no writeback", n_mwr - w, 0);
    do_op(3'd0, 8'h09, 8'h00);
    check("R8 old value", int'(rd_v), 8'h53);
  endtask

  task automatic t_outside_end();
    int m = n_mrd;
    do_op(3'd3, 8'h00, 8'h00);
    check("R10 commit idle", int'({tx_active, ab_v}), 0);
    do_op(3'd4, 8'h00, 8'h00);
    check("R10 abort idle", int'({tx_active, ab_v}), 0);
    do_op(3'd0, 8'h13, 8'h00);
    check("R10 line kept", int'(rd_v), 8'hC4);
    check("R10 line hit", n_mrd - m, 0);
  endtask

  initial begin
    t_reset();
    t_read_miss_hit();
    t_plain_writes();
    t_begin_flush();
    t_tx_write_commit();
    t_explicit_abort();
    t_conflict_write();
    t_conflict_read();
    t_evict_abort();
    t_outside_end();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule